// File: doc/BRIEF.md
# Asynchronous Host Bus Register Interface

This block is the slave end of a 16-bit asynchronous parallel host bus. The host drives an active-low chip select, active-low read and write strobes, a halfword address and a 16-bit data bus. The block turns these into accesses to an internal file of 32-bit registers. Each 32-bit register is reached by two 16-bit accesses. The low halfword comes first, and address bit 0 selects the half.

The three strobes are brought into the internal clock domain through two-flop synchronisers. The combined access windows are then edge-detected. The block also applies the recovery rules that follow a reset:
- A read that is already running when reset is released is ignored.
- Writes are discarded until the host completes a read.
- Pairing state is cleared, so the next access starts a fresh 32-bit cycle.

One fixed test word returns a constant pattern whose two halves differ, and it stays readable while reset is held. Some registers change only some time after a write. For these, a per-register hazard timer flags any read that arrives before the wait has elapsed.

Top module: `hbus_regif`

## Requirements
- R1: A read window is open only while both `cs_n` and `rd_n` are low, so it begins on the later of the two falling and ends on the earlier of the two rising. A write window is formed the same way from `cs_n` and `wr_n`. Strobe activity with `cs_n` high causes no register access.
- R2: A read with `addr[0]=0` (low half) of a normal word pulses `reg_re` for one cycle. It returns `reg_rdata[15:0]` on `dout` and captures the full 32-bit word. A later read with `addr[0]=1` returns the captured bits 31:16.
- R3: A low-half write stores `din` and its word address. A following high-half write to the same word pulses `reg_we` for one cycle, with `reg_waddr` set to the word and `reg_wdata = {high din, stored low din}`. A high-half write with no matching stored low half is dropped, and so is any write to the test word.
- R4: Word `TEST_WORD` (default 7) reads as the constant pattern 32'h8765_4321: low half 16'h4321, high half 16'h8765. It never pulses `reg_re`, and it reads correctly while `rst_n` is low.
- R5: If a read window is already open when `rst_n` rises, the rest of that window is ignored. It causes no `reg_re` and does not count as the read that unlocks writes.
- R6: After every reset, all writes are discarded until one complete read window has been seen after reset release.
- R7: Reset clears the pairing state. A high-half read before any low-half read returns 16'h0000. A high-half write whose low half came before the reset is dropped.
- R8: Each committed write loads every word's hazard timer with that word's wait, in clock cycles (default: word 2 = 12, word 3 = 3, all others 0). A low-half read of a word whose timer is nonzero raises `haz_err` for one cycle, and the read data is still returned.
- R9: Once a word's wait has elapsed, or when its wait is 0, a read of that word raises no `haz_err`.
- R10: While reset is held, `reg_re`, `reg_we` and `haz_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Asynchronous chip select, active low |
| rd_n | input | 1 | Asynchronous read strobe, active low |
| wr_n | input | 1 | Asynchronous write strobe, active low |
| addr | input | WA_W+1 | Halfword address: word index above bit 0, half select in bit 0 |
| din | input | HW | Host write data |
| dout | output | HW | Host read data |
| reg_raddr | output | WA_W | Register file read word address |
| reg_rdata | input | 2*HW | Register file read data |
| reg_re | output | 1 | One-cycle read side-effect pulse |
| reg_waddr | output | WA_W | Register file write word address |
| reg_wdata | output | 2*HW | Register file write data |
| reg_we | output | 1 | One-cycle write commit pulse |
| haz_err | output | 1 | One-cycle flag for a read inside a write hazard window |

## Verification
The hardest state to reach from the ports is a read window that straddles the release of reset. The internal synchronisers must already see the strobes active when `rst_n` rises. The stimulus therefore lowers `cs_n` and `rd_n` while reset is still held, releases reset a few cycles later and keeps the strobes low well past the synchroniser delay. It then shows that no read side effect occurred and that a following write is still discarded. A similar sequence stores a low-half write, pulses reset, and checks that the orphaned high half does not commit.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

   // Halfword select carried in address bit 0; the low half is accessed first.
   typedef enum logic {
      HALF_LO = 1'b0,
      HALF_HI = 1'b1
   } half_e;

endpackage

// File: rtl/hbus_sync.sv
// Two-flop synchroniser bank. No reset: the flops keep tracking the pins
// during reset so the true strobe level is known at reset release.
module hbus_sync #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q
);

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic meta_q;
      logic sync_q;
      always_ff @(posedge clk) begin
         meta_q <= d_async[i];
         sync_q <= meta_q;
      end
      assign q[i] = sync_q;
   end

endmodule

// File: rtl/hbus_rstq.sv
// Reset qualification: masks a read window that was open at reset release
// and keeps writes closed until one qualified read has ended.
module hbus_rstq (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_act,
   output logic rd_blk,
   output logic rd_start,
   output logic wr_open
);

   logic live;
   logic live_q;
   logic rd_end;

   assign live     = rd_act & ~rd_blk;
   assign rd_start = live & ~live_q;
   assign rd_end   = ~live & live_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_blk  <= 1'b1;
         live_q  <= 1'b0;
         wr_open <= 1'b0;
      end else begin
         if (!rd_act) rd_blk <= 1'b0;
         live_q <= live;
         if (rd_end) wr_open <= 1'b1;
      end
   end

endmodule

// File: rtl/hbus_pair.sv
// Halfword pairing: read capture on the low half, write commit on the high half.
module hbus_pair
   import hbus_pkg::*;
#(
   parameter int              HW           = 16,
   parameter int              WA_W         = 3,
   parameter int              TEST_WORD    = 7,
   parameter logic [2*HW-1:0] TEST_PATTERN = 32'h8765_4321
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_start,
   input  logic            wr_act,
   input  logic            wr_open,
   input  logic [WA_W-1:0] word,
   input  half_e           half,
   input  logic [HW-1:0]   din,
   input  logic [2*HW-1:0] reg_rdata,
   output logic [2*HW-1:0] rd_hold,
   output logic            reg_re,
   output logic            reg_we,
   output logic [WA_W-1:0] reg_waddr,
   output logic [2*HW-1:0] reg_wdata,
   output logic            chk_stb,
   output logic [WA_W-1:0] chk_word
);

   localparam logic [WA_W-1:0] TEST_IDX = WA_W'(TEST_WORD);

   logic            is_test;
   logic            wr_q;
   logic            wr_start;
   logic            wr_pend;
   logic [WA_W-1:0] wr_word;
   logic [HW-1:0]   wr_lo;

   assign is_test  = (word == TEST_IDX);
   assign wr_start = wr_act & ~wr_q & wr_open;
   assign chk_stb  = rd_start & (half == HALF_LO) & ~is_test;
   assign chk_word = word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_hold   <= '0;
         reg_re    <= 1'b0;
         reg_we    <= 1'b0;
         reg_waddr <= '0;
         reg_wdata <= '0;
         wr_q      <= 1'b0;
         wr_pend   <= 1'b0;
         wr_word   <= '0;
         wr_lo     <= '0;
      end else begin
         reg_re <= 1'b0;
         reg_we <= 1'b0;
         wr_q   <= wr_act;
         if (rd_start && half == HALF_LO) begin
            rd_hold <= is_test ? TEST_PATTERN : reg_rdata;
            reg_re  <= ~is_test;
         end
         if (wr_start) begin
            if (half == HALF_LO) begin
               wr_lo   <= din;
               wr_word <= word;
               wr_pend <= 1'b1;
            end else begin
               wr_pend <= 1'b0;
               if (wr_pend && wr_word == word && !is_test) begin
                  reg_we    <= 1'b1;
                  reg_waddr <= word;
                  reg_wdata <= {din, wr_lo};
               end
            end
         end
      end
   end

endmodule

// File: rtl/hbus_hazard.sv
// Per-word write-to-read hazard timers. Words with a zero wait get no counter.
module hbus_hazard #(
   parameter int                          NUM_WORDS = 8,
   parameter int                          CNT_W     = 4,
   parameter logic [NUM_WORDS*CNT_W-1:0]  WAIT      = 32'h0000_3C00,
   localparam int                         WA_W      = $clog2(NUM_WORDS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ld,
   input  logic            chk_stb,
   input  logic [WA_W-1:0] chk_word,
   output logic            haz_err
);

   logic [NUM_WORDS-1:0] busy;

   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      localparam logic [CNT_W-1:0] WAIT_I = WAIT[i*CNT_W +: CNT_W];
      if (WAIT_I == '0) begin : g_none
         assign busy[i] = 1'b0;
      end else begin : g_tmr
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt <= '0;
            else if (ld)          cnt <= WAIT_I;
            else if (cnt != '0)   cnt <= cnt - 1'b1;
         end
         assign busy[i] = (cnt != '0);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) haz_err <= 1'b0;
      else        haz_err <= chk_stb & busy[chk_word];
   end

endmodule

// File: rtl/hbus_regif.sv
module hbus_regif
   import hbus_pkg::*;
#(
   parameter int                          HW           = 16,
   parameter int                          NUM_WORDS    = 8,
   parameter int                          CNT_W        = 4,
   parameter int                          TEST_WORD    = 7,
   parameter logic [2*HW-1:0]             TEST_PATTERN = 32'h8765_4321,
   parameter logic [NUM_WORDS*CNT_W-1:0]  HAZ_WAIT     = 32'h0000_3C00,
   localparam int                         WA_W         = $clog2(NUM_WORDS),
   localparam int                         AW           = WA_W + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cs_n,
   input  logic            rd_n,
   input  logic            wr_n,
   input  logic [AW-1:0]   addr,
   input  logic [HW-1:0]   din,
   output logic [HW-1:0]   dout,
   output logic [WA_W-1:0] reg_raddr,
   input  logic [2*HW-1:0] reg_rdata,
   output logic            reg_re,
   output logic [WA_W-1:0] reg_waddr,
   output logic [2*HW-1:0] reg_wdata,
   output logic            reg_we,
   output logic            haz_err
);

   if (NUM_WORDS < 2 || (1 << WA_W) != NUM_WORDS) begin : g_chk_words
      $error("NUM_WORDS must be a power of two of at least 2");
   end
   if (TEST_WORD < 0 || TEST_WORD >= NUM_WORDS) begin : g_chk_test
      $error("TEST_WORD out of range");
   end
   if (TEST_PATTERN[2*HW-1:HW] == TEST_PATTERN[HW-1:0]) begin : g_chk_pat
      $error("TEST_PATTERN halves must differ");
   end

   localparam logic [WA_W-1:0] TEST_IDX = WA_W'(TEST_WORD);

   logic [2:0]      pin_raw;
   logic [2:0]      pin_s;
   logic            rd_act;
   logic            wr_act;
   logic            rd_blk;
   logic            rd_start;
   logic            wr_open;
   logic [WA_W-1:0] word;
   half_e           half;
   logic [2*HW-1:0] rd_hold;
   logic            chk_stb;
   logic [WA_W-1:0] chk_word;

   assign pin_raw = {cs_n, rd_n, wr_n};

   hbus_sync #(.W(3)) u_sync (
      .clk     (clk),
      .d_async (pin_raw),
      .q       (pin_s)
   );

   assign rd_act = ~pin_s[2] & ~pin_s[1];
   assign wr_act = ~pin_s[2] & ~pin_s[0];
   assign word   = addr[AW-1:1];
   assign half   = half_e'(addr[0]);

   hbus_rstq u_rstq (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_act   (rd_act),
      .rd_blk   (rd_blk),
      .rd_start (rd_start),
      .wr_open  (wr_open)
   );

   hbus_pair #(
      .HW           (HW),
      .WA_W         (WA_W),
      .TEST_WORD    (TEST_WORD),
      .TEST_PATTERN (TEST_PATTERN)
   ) u_pair (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_start  (rd_start),
      .wr_act    (wr_act),
      .wr_open   (wr_open),
      .word      (word),
      .half      (half),
      .din       (din),
      .reg_rdata (reg_rdata),
      .rd_hold   (rd_hold),
      .reg_re    (reg_re),
      .reg_we    (reg_we),
      .reg_waddr (reg_waddr),
      .reg_wdata (reg_wdata),
      .chk_stb   (chk_stb),
      .chk_word  (chk_word)
   );

   hbus_hazard #(
      .NUM_WORDS (NUM_WORDS),
      .CNT_W     (CNT_W),
      .WAIT      (HAZ_WAIT)
   ) u_haz (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld       (reg_we),
      .chk_stb  (chk_stb),
      .chk_word (chk_word),
      .haz_err  (haz_err)
   );

   assign reg_raddr = word;

   // Test word is decoded straight from the address so it reads during reset.
   always_comb begin
      if (word == TEST_IDX)
         dout = (half == HALF_HI) ? TEST_PATTERN[2*HW-1:HW] : TEST_PATTERN[HW-1:0];
      else if (half == HALF_HI)
         dout = rd_hold[2*HW-1:HW];
      else
         dout = reg_rdata[HW-1:0];
   end

endmodule

// File: rtl/hbus_regif_chk.sv
module hbus_regif_chk (
   input logic clk,
   input logic rst_n,
   input logic reg_we,
   input logic reg_re,
   input logic haz_err,
   input logic wr_open,
   input logic rd_blk,
   input logic rd_start
);

   // R6: a commit only happens once the write gate was already open
   p_we_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> $past(wr_open));

   // R5: no read side effect while the post-reset read tail is masked
   p_no_tail_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |-> !$past(rd_blk));

   // R8: a hazard flag always follows a read window start
   p_haz_from_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
      haz_err |-> $past(rd_start));

   // R3: a write commit is a single-cycle pulse
   p_we_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   // R2: a read side effect is a single-cycle pulse
   p_re_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      reg_re |=> !reg_re);

endmodule

bind hbus_regif hbus_regif_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_we   (reg_we),
   .reg_re   (reg_re),
   .haz_err  (haz_err),
   .wr_open  (wr_open),
   .rd_blk   (rd_blk),
   .rd_start (rd_start)
);

// File: tb/hbus_regif_tb.sv
module hbus_regif_tb;

   localparam int          NW  = 8;
   localparam int          TW  = 7;
   localparam logic [31:0] PAT = 32'h8765_4321;
   localparam int          NV  = 5;
   localparam logic [34:0] VEC [NV] = '{
      {3'd0, 32'h0000_1234},
      {3'd4, 32'hDEAD_BEEF},
      {3'd5, 32'h0F0F_F0F0},
      {3'd6, 32'h8000_0001},
      {3'd3, 32'h3333_CCCC}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cs_n, rd_n, wr_n;
   logic [3:0]  addr;
   logic [15:0] din;
   logic [15:0] dout;
   logic [2:0]  reg_raddr, reg_waddr;
   logic [31:0] reg_rdata, reg_wdata;
   logic        reg_re, reg_we, haz_err;

   always #10 clk = ~clk;

   hbus_regif u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
      .addr(addr), .din(din), .dout(dout),
      .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .reg_re(reg_re),
      .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_we(reg_we),
      .haz_err(haz_err)
   );

   logic [31:0] mem [NW] = '{default: 32'h0};
   always @(posedge clk) if (reg_we) mem[reg_waddr] <= reg_wdata;
   assign reg_rdata = mem[reg_raddr];

   int          we_cnt = 0, re_cnt = 0, err_cnt = 0;
   logic [31:0] last_wd = '0;
   logic [2:0]  last_wa = '0;
   always @(posedge clk) begin
      if (reg_we) begin we_cnt++; last_wd = reg_wdata; last_wa = reg_waddr; end
      if (reg_re) re_cnt++;
      if (haz_err) err_cnt++;
   end

   int errors = 0, checks = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic host_rd(input int w, input logic h, output logic [15:0] d);
      @(negedge clk); addr = {w[2:0], h}; cs_n = 1'b0; rd_n = 1'b0;
      repeat (5) @(negedge clk);
      d = dout; cs_n = 1'b1; rd_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic host_wr(input int w, input logic h, input logic [15:0] v);
      @(negedge clk); addr = {w[2:0], h}; din = v; cs_n = 1'b0; wr_n = 1'b0;
      repeat (5) @(negedge clk);
      cs_n = 1'b1; wr_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic wr32(input int w, input logic [31:0] v);
      host_wr(w, 1'b0, v[15:0]);
      host_wr(w, 1'b1, v[31:16]);
   endtask

   task automatic rd32(input int w, output logic [31:0] v);
      logic [15:0] lo, hi;
      host_rd(w, 1'b0, lo);
      host_rd(w, 1'b1, hi);
      v = {hi, lo};
   endtask

   task automatic pulse_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0] d;
      logic [31:0] v;
      int          n;
      rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = '0; din = '0;
      repeat (4) @(negedge clk);

      // R10: quiet outputs in reset
      chk("R10 reg_we", {31'd0, reg_we}, 32'd0);
      chk("R10 reg_re", {31'd0, reg_re}, 32'd0);
      chk("R10 haz_err", {31'd0, haz_err}, 32'd0);

      // R4: test word readable while reset is held
      host_rd(TW, 1'b0, d); chk("R4 test lo in reset", {16'd0, d}, {16'd0, PAT[15:0]});
      host_rd(TW, 1'b1, d); chk("R4 test hi in reset", {16'd0, d}, {16'd0, PAT[31:16]});

      // R5: read window already open when reset is released
      @(negedge clk); addr = {3'd1, 1'b0}; cs_n = 1'b0; rd_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      repeat (6) @(negedge clk); cs_n = 1'b1; rd_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R5 no side effect from tail", re_cnt, 0);

      // R6: writes dropped (the tail did not unlock)
      wr32(1, 32'hCAFE_0001);
      chk("R6 locked write dropped", we_cnt, 0);

      // R7: high half read with nothing captured since reset
      host_rd(1, 1'b1, d);
      chk("R7 high half after reset", {16'd0, d}, 32'd0);

      // R1: read strobe without chip select
      @(negedge clk); addr = {3'd1, 1'b0}; rd_n = 1'b0;
      repeat (6) @(negedge clk); rd_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 no access without cs_n", re_cnt, 0);
      // R1: staggered strobes, cs_n first, rd_n released first
      @(negedge clk); cs_n = 1'b0;
      repeat (2) @(negedge clk); rd_n = 1'b0;
      repeat (4) @(negedge clk); rd_n = 1'b1;
      repeat (2) @(negedge clk); cs_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 staggered window one read", re_cnt, 1);

      // R3: write pairing now unlocked
      wr32(1, 32'hCAFE_0001);
      chk("R3 commit count", we_cnt, 1);
      chk("R3 commit addr", {29'd0, last_wa}, 32'd1);
      chk("R3 commit data", last_wd, 32'hCAFE_0001);

      // R2: table of write/read-back vectors
      for (int i = 0; i < NV; i++) begin
         wr32(int'(VEC[i][34:32]), VEC[i][31:0]);
         repeat (20) @(negedge clk);
         n = re_cnt;
         rd32(int'(VEC[i][34:32]), v);
         chk("R2 read back", v, VEC[i][31:0]);
         chk("R2 one side effect", re_cnt, n + 1);
      end
      chk("R9 no hazard after waits", err_cnt, 0);

      // R3: orphan and mismatched high halves, test word write
      n = we_cnt;
      host_wr(4, 1'b1, 16'h1111);
      chk("R3 orphan high dropped", we_cnt, n);
      host_wr(5, 1'b0, 16'h2222);
      host_wr(4, 1'b1, 16'h3333);
      chk("R3 mismatched word dropped", we_cnt, n);
      wr32(TW, 32'h0000_0000);
      chk("R3 test word write dropped", we_cnt, n);
      n = re_cnt;
      host_rd(TW, 1'b0, d);
      chk("R4 test lo after write", {16'd0, d}, {16'd0, PAT[15:0]});
      chk("R4 no side effect", re_cnt, n);

      // R8: read inside the hazard window
      wr32(2, 32'h2222_ABCD);
      host_rd(2, 1'b0, d);
      chk("R8 hazard flagged", err_cnt, 1);
      chk("R8 data still served", {16'd0, d}, 32'h0000_ABCD);
      repeat (20) @(negedge clk);
      host_rd(2, 1'b0, d);
      chk("R9 after wait", err_cnt, 1);
      wr32(3, 32'h3030_0303);
      host_rd(3, 1'b0, d);
      chk("R9 short wait elapsed", err_cnt, 1);
      wr32(2, 32'h2020_0202);
      host_rd(5, 1'b0, d);
      chk("R9 zero-wait word", err_cnt, 1);

      // R7/R6: reset between halves
      repeat (20) @(negedge clk);
      host_wr(6, 1'b0, 16'h7777);
      pulse_reset();
      n = we_cnt;
      wr32(5, 32'h5555_5555);
      chk("R6 locked after second reset", we_cnt, n);
      host_rd(6, 1'b1, d);
      chk("R7 hold cleared", {16'd0, d}, 32'd0);
      host_wr(6, 1'b1, 16'h6666);
      chk("R7 pre-reset low half discarded", we_cnt, n);
      wr32(6, 32'h6666_7777);
      chk("R3 fresh pair commits", last_wd, 32'h6666_7777);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule